// File: doc/BRIEF.md
# Hiccup Fault Protection Controller

This block supervises faults in the digital core of a step-down switching regulator. Once per switching cycle it receives a strobe, along with flags from the analog side. The flags report a peak overcurrent hit, a valley (negative) overcurrent hit, output overvoltage, input undervoltage, input overvoltage and over-temperature. A separate flag reports that soft-start has completed. The block decides when switching must stop and when power-good must be held low. On a negative-limit hit it forces the high-side switch on for a fixed pulse. It also signals when a restart may begin.

The two current limits each feed their own saturating up-down counter. A hit cycle counts up and a clean cycle counts down, stopping at zero. Each counter has its own trip count. Output overvoltage is only watched once soft-start is done, and it must last for a deglitch window before it counts as a fault. Input lockout and over-temperature stop switching at once. Every fault starts a hiccup wait of fixed length. After the wait, the block restarts once all level conditions (input lockout, over-temperature, output overvoltage) have cleared. Overcurrent trips restart without such a condition. Both counters are emptied as the restart begins.

Top module: `hiccup_fault_ctrl`

## Requirements
- R1: After reset, `sw_stop`, `hs_force` and `restart_ok` are 0.
- R2: The peak counter adds one on each strobe with `pk_oc` high and subtracts one on each strobe without it. When the count exceeds POS_TRIP (default 512), `sw_stop` rises on the next clock.
- R3: The peak and valley counters never go below zero: clean strobes at a count of zero leave the count at zero.
- R4: The valley counter works the same way but on `vl_oc`, independently, and trips when its count exceeds NEG_TRIP (default 1024).
- R5: A strobe with `vl_oc` high while running drives `hs_force` high for exactly PULSE_CLKS clocks, starting at the clock edge that samples the strobe.
- R6: `out_ov` has no effect while `ss_done` is low.
- R7: With `ss_done` high, `out_ov` must stay high for OV_DGL_CLKS consecutive clocks before it causes a stop. A shorter burst causes no stop.
- R8: `in_uv`, `in_ov` or `ot_hot` high while running makes `sw_stop` rise on the next clock.
- R9: While stopped, `pg_pull_low` is 1, `hs_force` is 0, and strobes with overcurrent flags are ignored.
- R10: With all conditions clear, a stop lasts exactly HICCUP_CLKS+1 clocks. `restart_ok` is high for exactly one clock, which is the last clock of the stop.
- R11: After the hiccup wait, the restart is held off for as long as `in_uv`, `in_ov`, `ot_hot` or `out_ov` is high. It follows one clock after they clear.
- R12: Both counters are zero when running resumes after a restart.
- R13: `pg_pull_low` is 1 whenever `ss_done` is low or switching is stopped, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_stb | input | 1 | One-clock strobe per switching cycle |
| pk_oc | input | 1 | Peak current limit hit in this cycle |
| vl_oc | input | 1 | Valley (negative) current limit hit in this cycle |
| out_ov | input | 1 | Output overvoltage comparator |
| in_uv | input | 1 | Input undervoltage lockout |
| in_ov | input | 1 | Input overvoltage lockout |
| ot_hot | input | 1 | Over-temperature flag (hysteresis applied upstream) |
| ss_done | input | 1 | Soft-start ramp complete |
| sw_stop | output | 1 | Request to stop switching |
| pg_pull_low | output | 1 | Hold power-good low |
| hs_force | output | 1 | Force high-side switch on |
| restart_ok | output | 1 | Restart may begin (one clock) |

## Verification
The assertions assume certain things about the inputs. `cyc_stb` is a single-clock pulse. The overcurrent flags matter only in a strobe clock. The level flags are synchronous to `clk`. The stimulus changes every input on the falling edge and holds `cyc_stb` high for exactly one rising edge. During the hiccup wait it deliberately keeps the strobe and both overcurrent flags high to show that they are ignored. The trip counts and timers are reduced through parameters so that every trip, deglitch window and hiccup wait fits within a short run.

// File: rtl/fault_sup_pkg.sv
package fault_sup_pkg;
   typedef enum logic {
      SUP_RUN    = 1'b0,
      SUP_HICCUP = 1'b1
   } sup_state_e;
endpackage

// File: rtl/fs_evt_counter.sv
module fs_evt_counter #(
   parameter int TRIP = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic evt,
   input  logic clr,
   output logic trip
);
   localparam int W = $clog2(TRIP + 2);
   localparam logic [W-1:0] TOP = W'(TRIP + 1);

   if (TRIP < 1) begin : g_bad_trip
      $error("fs_evt_counter: TRIP must be at least 1");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (en) begin
         if (evt) begin
            if (cnt != TOP) cnt <= cnt + W'(1);
         end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
         end
      end
   end

   assign trip = (cnt == TOP);

   AST_CNT_CEILING: assert property (@(posedge clk) disable iff (!rst_n) cnt <= TOP); // R2
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !evt && !clr && cnt == '0) |=> cnt == '0); // R3
   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && evt && !clr && cnt != TOP) |=> cnt == $past(cnt) + W'(1)); // R2
   AST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !trip); // R12
endmodule

// File: rtl/fs_hs_pulse.sv
module fs_hs_pulse #(
   parameter int PULSE_CLKS = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic active
);
   localparam int W = $clog2(PULSE_CLKS + 1);
   localparam logic [W-1:0] LEN = W'(PULSE_CLKS);

   if (PULSE_CLKS < 1) begin : g_bad_len
      $error("fs_hs_pulse: PULSE_CLKS must be at least 1");
   end

   logic [W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          left <= '0;
      else if (fire)       left <= LEN;
      else if (left != '0) left <= left - W'(1);
   end

   assign active = (left != '0);

   AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n) fire |=> active); // R5
endmodule

// File: rtl/fs_ov_filter.sv
module fs_ov_filter #(
   parameter int DGL_CLKS = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ov_raw,
   input  logic armed,
   output logic ov_trip
);
   logic live;
   assign live = ov_raw & armed;

   if (DGL_CLKS == 0) begin : g_direct
      assign ov_trip = live;
   end else begin : g_filtered
      localparam int W = $clog2(DGL_CLKS + 1);
      localparam logic [W-1:0] LIM = W'(DGL_CLKS);
      logic [W-1:0] run_len;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            run_len <= '0;
         else if (!live)        run_len <= '0;
         else if (run_len != LIM) run_len <= run_len + W'(1);
      end

      assign ov_trip = live & (run_len == LIM);

      AST_BREAK_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
         !live |=> !ov_trip); // R7
   end
endmodule

// File: rtl/hiccup_fault_ctrl.sv
module hiccup_fault_ctrl
   import fault_sup_pkg::*;
#(
   parameter int POS_TRIP    = 512,
   parameter int NEG_TRIP    = 1024,
   parameter int PULSE_CLKS  = 9,
   parameter int OV_DGL_CLKS = 100,
   parameter int HICCUP_CLKS = 1_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_stb,
   input  logic pk_oc,
   input  logic vl_oc,
   input  logic out_ov,
   input  logic in_uv,
   input  logic in_ov,
   input  logic ot_hot,
   input  logic ss_done,
   output logic sw_stop,
   output logic pg_pull_low,
   output logic hs_force,
   output logic restart_ok
);
   localparam int TW = $clog2(HICCUP_CLKS + 1);
   localparam logic [TW-1:0] HIC_END = TW'(HICCUP_CLKS);

   if (HICCUP_CLKS < 1) begin : g_bad_hiccup
      $error("hiccup_fault_ctrl: HICCUP_CLKS must be at least 1");
   end
   if (OV_DGL_CLKS < 0) begin : g_bad_dgl
      $error("hiccup_fault_ctrl: OV_DGL_CLKS must not be negative");
   end

   sup_state_e      state;
   logic [TW-1:0]   hic_tmr;
   logic            running, cnt_en, counters_clr;
   logic            pos_trip, neg_trip, ov_trip, pulse_on;
   logic            any_fault, levels_clear, hic_done;

   assign running      = (state == SUP_RUN);
   assign cnt_en       = running & cyc_stb;
   assign counters_clr = restart_ok;

   fs_evt_counter #(.TRIP(POS_TRIP)) i_pos_cnt (
      .clk(clk), .rst_n(rst_n), .en(cnt_en), .evt(pk_oc),
      .clr(counters_clr), .trip(pos_trip));

   fs_evt_counter #(.TRIP(NEG_TRIP)) i_neg_cnt (
      .clk(clk), .rst_n(rst_n), .en(cnt_en), .evt(vl_oc),
      .clr(counters_clr), .trip(neg_trip));

   fs_hs_pulse #(.PULSE_CLKS(PULSE_CLKS)) i_hs_pulse (
      .clk(clk), .rst_n(rst_n), .fire(cnt_en & vl_oc), .active(pulse_on));

   fs_ov_filter #(.DGL_CLKS(OV_DGL_CLKS)) i_ov_filt (
      .clk(clk), .rst_n(rst_n), .ov_raw(out_ov), .armed(ss_done), .ov_trip(ov_trip));

   assign any_fault    = pos_trip | neg_trip | ov_trip | in_uv | in_ov | ot_hot;
   assign levels_clear = ~(in_uv | in_ov | ot_hot | out_ov);
   assign hic_done     = (hic_tmr == HIC_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SUP_RUN;
         hic_tmr <= '0;
      end else begin
         case (state)
            SUP_RUN: begin
               hic_tmr <= '0;
               if (any_fault) state <= SUP_HICCUP;
            end
            default: begin
               if (!hic_done) hic_tmr <= hic_tmr + TW'(1);
               if (hic_done && levels_clear) state <= SUP_RUN;
            end
         endcase
      end
   end

   assign sw_stop     = ~running;
   assign pg_pull_low = ~running | ~ss_done;
   assign hs_force    = running & pulse_on;
   assign restart_ok  = ~running & hic_done & levels_clear;

   AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (running && (in_uv || in_ov || ot_hot)) |=> sw_stop); // R8
   AST_STOP_PG: assert property (@(posedge clk) disable iff (!rst_n)
      sw_stop |-> pg_pull_low); // R9
   AST_NO_FORCE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      sw_stop |-> !hs_force); // R9
   AST_OV_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !ss_done |-> !ov_trip); // R6
   AST_RESTART_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
      restart_ok |=> !sw_stop); // R10
   AST_RESTART_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      restart_ok |=> !restart_ok); // R10
   AST_LOCKOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_stop && in_uv) |=> sw_stop); // R11
endmodule

// File: tb/test_hiccup_fault_ctrl.sv
`timescale 1ns/1ps
module test_hiccup_fault_ctrl;
   localparam int P_TRIP = 6;
   localparam int N_TRIP = 10;
   localparam int PULSE  = 4;
   localparam int DGL    = 5;
   localparam int HIC    = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cyc_stb = 0, pk_oc = 0, vl_oc = 0, out_ov = 0;
   logic in_uv = 0, in_ov = 0, ot_hot = 0, ss_done = 0;
   logic sw_stop, pg_pull_low, hs_force, restart_ok;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   typedef struct { string req; int exp; } exp_item_t;
   exp_item_t sb_q[$];

   always #10 clk = ~clk;

   hiccup_fault_ctrl #(
      .POS_TRIP(P_TRIP), .NEG_TRIP(N_TRIP), .PULSE_CLKS(PULSE),
      .OV_DGL_CLKS(DGL), .HICCUP_CLKS(HIC)
   ) i_hiccup_fault_ctrl (
      .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .pk_oc(pk_oc), .vl_oc(vl_oc),
      .out_ov(out_ov), .in_uv(in_uv), .in_ov(in_ov), .ot_hot(ot_hot), .ss_done(ss_done),
      .sw_stop(sw_stop), .pg_pull_low(pg_pull_low), .hs_force(hs_force),
      .restart_ok(restart_ok));

   // driver side: push the expected value
   task automatic expect_item(input string req, input int exp);
      exp_item_t it;
      it.req = req;
      it.exp = exp;
      sb_q.push_back(it);
   endtask

   // monitor side: pop and compare against the observed value
   task automatic observe(input int act);
      exp_item_t it;
      it = sb_q.pop_front();
      n_checks++;
      if (act != it.exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", it.req, act, it.exp);
      end
   endtask

   task automatic chk(input string req, input int act, input int exp);
      expect_item(req, exp);
      observe(act);
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic strobe(input logic p, input logic v);
      cyc_stb = 1'b1; pk_oc = p; vl_oc = v;
      @(negedge clk);
      cyc_stb = 1'b0; pk_oc = 1'b0; vl_oc = 1'b0;
   endtask

   // entered with sw_stop already high; hammer keeps overcurrent strobes active
   task automatic ride_hiccup(input bit hammer, output int len, output int rseen,
                              output int rpos, output int force_seen);
      len = 1; rseen = 0; rpos = 0; force_seen = 0;
      for (int g = 0; g < 1000; g++) begin
         if (restart_ok) begin rseen++; rpos = len; end
         if (hs_force) force_seen++;
         cyc_stb = hammer; pk_oc = hammer; vl_oc = hammer;
         @(negedge clk);
         cyc_stb = 1'b0; pk_oc = 1'b0; vl_oc = 1'b0;
         if (sw_stop) len++;
         else break;
      end
   endtask

   initial begin
      for (int w = 0; w < 150000; w++) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual 0 expected 1 (run completed)");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int len, rseen, rpos, fseen, hi;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 / R13 reset state
      chk("R1 sw_stop", sw_stop, 0);
      chk("R1 hs_force", hs_force, 0);
      chk("R1 restart_ok", restart_ok, 0);
      chk("R13 pg low before soft-start", pg_pull_low, 1);
      ss_done = 1'b1;
      tick(1);
      chk("R13 pg released", pg_pull_low, 0);

      // R5 forced high-side pulse
      strobe(1'b0, 1'b1);
      hi = 0;
      for (int k = 0; k < 12; k++) begin
         if (hs_force) hi++;
         tick(1);
      end
      chk("R5 pulse length", hi, PULSE);
      strobe(1'b0, 1'b0);
      strobe(1'b0, 1'b0);

      // R2 up-down counting then trip
      for (int k = 0; k < P_TRIP; k++) strobe(1'b1, 1'b0);
      strobe(1'b0, 1'b0);
      strobe(1'b1, 1'b0);
      chk("R2 at limit no stop", sw_stop, 0);
      strobe(1'b1, 1'b0);
      chk("R2 not yet stopped", sw_stop, 0);
      tick(1);
      chk("R2 stop after exceed", sw_stop, 1);
      chk("R9 pg low when stopped", pg_pull_low, 1);
      ride_hiccup(1'b1, len, rseen, rpos, fseen);
      chk("R9 no force while stopped", fseen, 0);
      chk("R10 hiccup length", len, HIC + 1);
      chk("R10 restart_ok count", rseen, 1);
      chk("R10 restart_ok position", rpos, HIC + 1);
      chk("R13 pg released after restart", pg_pull_low, 0);

      // R12 counters cleared on restart (and R9 ignored strobes)
      for (int k = 0; k < P_TRIP; k++) strobe(1'b1, 1'b0);
      tick(1);
      chk("R12 no trip after restart", sw_stop, 0);
      for (int k = 0; k < P_TRIP + 2; k++) strobe(1'b0, 1'b0);

      // R3 floor at zero
      for (int k = 0; k < 5; k++) strobe(1'b0, 1'b0);
      for (int k = 0; k < P_TRIP; k++) strobe(1'b1, 1'b0);
      tick(1);
      chk("R3 no wrap below zero", sw_stop, 0);
      strobe(1'b1, 1'b0);
      tick(1);
      chk("R3 trips at exact count", sw_stop, 1);
      ride_hiccup(1'b0, len, rseen, rpos, fseen);
      chk("R10 hiccup length again", len, HIC + 1);

      // R4 negative counter
      for (int k = 0; k < N_TRIP; k++) strobe(1'b0, 1'b1);
      tick(1);
      chk("R4 at limit no stop", sw_stop, 0);
      strobe(1'b0, 1'b1);
      tick(1);
      chk("R4 stop after exceed", sw_stop, 1);
      chk("R9 force dropped on stop", hs_force, 0);
      ride_hiccup(1'b0, len, rseen, rpos, fseen);
      tick(PULSE + 1);

      // R6 overvoltage ignored before soft-start done
      ss_done = 1'b0; out_ov = 1'b1;
      tick(20);
      chk("R6 ov ignored", sw_stop, 0);
      chk("R13 pg low without soft-start", pg_pull_low, 1);
      out_ov = 1'b0; ss_done = 1'b1;
      tick(2);

      // R7 deglitch
      out_ov = 1'b1;
      tick(DGL - 1);
      out_ov = 1'b0;
      tick(1);
      out_ov = 1'b1;
      tick(DGL - 1);
      chk("R7 short bursts ignored", sw_stop, 0);
      out_ov = 1'b0;
      tick(1);
      out_ov = 1'b1;
      tick(DGL);
      chk("R7 window not yet closed", sw_stop, 0);
      tick(1);
      chk("R7 persistent ov stops", sw_stop, 1);
      out_ov = 1'b0;
      ride_hiccup(1'b0, len, rseen, rpos, fseen);
      chk("R10 hiccup length after ov", len, HIC + 1);

      // R8 immediate lockouts
      in_ov = 1'b1;
      tick(1);
      chk("R8 input ov stops", sw_stop, 1);
      in_ov = 1'b0;
      ride_hiccup(1'b0, len, rseen, rpos, fseen);
      ot_hot = 1'b1;
      tick(1);
      chk("R8 over-temperature stops", sw_stop, 1);
      ot_hot = 1'b0;
      ride_hiccup(1'b0, len, rseen, rpos, fseen);

      // R11 restart waits for lockout to clear
      in_uv = 1'b1;
      tick(1);
      chk("R8 input uv stops", sw_stop, 1);
      rseen = 0;
      for (int k = 0; k < HIC + 20; k++) begin
         if (restart_ok) rseen++;
         tick(1);
      end
      chk("R11 held while uv", sw_stop, 1);
      chk("R11 no restart_ok while uv", rseen, 0);
      in_uv = 1'b0;
      tick(1);
      chk("R11 restart after clear", sw_stop, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule